// File: doc/BRIEF.md
# Next-Line Prefetch Request Injector

This block sits inside a load/store unit, between the issue stage and the request port of the data cache. Issue presents a demand memory operation on a valid/ready handshake. The operation carries one base address per lane, a shared offset, a read/write flag and a lane enable mask. The block adds the offset to every base to form the effective lane addresses. It then places the request in a single-entry request register, and that register drives the cache.

When the accepted demand is a load with at least one enabled lane, the block creates a follow-up request for the next word: every lane address is advanced by the word size, the mask is copied and the read flag is forced on. This prefetch goes into the same register as soon as the cache can take it. A metadata bit on the output marks each request as either a demand or a prefetch, so the response side can tell them apart. While a prefetch waits, the block holds off the issue stage so that the two requests never compete for the register.

Top module: `nlp_inject`

## Requirements
- R1: Each output lane address of a demand request equals that lane's base plus the offset, modulo 2^AW. It appears on `req_addr` in the cycle after the handshake.
- R2: A demand is accepted in a cycle where `dmd_valid` and `dmd_ready` are both 1. `dmd_ready` is 1 exactly when `cache_ready` is 1 and no prefetch is waiting.
- R3: An accepted demand appears on the output in the next cycle with `req_valid`=1 and `req_is_pf`=0, carrying its own read flag and lane mask.
- R4: An accepted read whose lane mask is not zero is followed by a prefetch. The prefetch has `req_is_pf`=1, `req_read`=1, the same lane mask, and each lane address equal to the demand's effective address plus WORD_BYTES (default 4), modulo 2^AW.
- R5: An accepted write, or an accepted read with an all-zero mask, creates no prefetch. `dmd_ready` follows `cache_ready` in the next cycle.
- R6: From the cycle after a prefetch-triggering handshake until that prefetch has entered the register, `dmd_ready` is 0.
- R7: While `cache_ready` is 0, the output request (valid, addresses, flag, mask, prefetch bit) is held unchanged at the next edge. A waiting prefetch keeps its addresses and mask.
- R8: When `cache_ready` is 1 and neither a demand handshake nor a waiting prefetch is present, `req_valid` is 0 in the next cycle.
- R9: Reset clears `req_valid` and any waiting prefetch, so that `dmd_ready` equals `cache_ready` right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmd_valid | input | 1 | Demand request valid from issue |
| dmd_ready | output | 1 | Block can accept a demand this cycle |
| dmd_base | input | LANES*AW | Per-lane base addresses, lane 0 in the low bits |
| dmd_offset | input | AW | Offset added to every lane base |
| dmd_read | input | 1 | 1 for a load, 0 for a store |
| dmd_lane_en | input | LANES | Per-lane valid bits |
| cache_ready | input | 1 | Cache is not busy and takes the register content |
| req_valid | output | 1 | Request register holds a request |
| req_addr | output | LANES*AW | Per-lane request addresses |
| req_read | output | 1 | Read flag of the held request |
| req_lane_en | output | LANES | Lane mask of the held request |
| req_is_pf | output | 1 | 1 when the held request is a prefetch |

## Verification
A demand handshake is visible on the request outputs exactly one clock later, because only the request register lies in that path. The prefetch it spawns appears one clock after the first later cycle in which `cache_ready` is 1, which is the next cycle at the earliest. `dmd_ready` is combinational, so it is due in the same cycle as `cache_ready` and the pending state. The bench drives inputs just after the falling edge and checks `dmd_ready` a moment later. It compares the request outputs at the following falling edge against a cycle model that it advanced at the rising edge between them. Each comparison therefore lands on the one cycle that the register count allows.

// File: rtl/nlp_pkg.sv
// Shared types of the next-line prefetch injector.
// Assumes: the parameters that set widths live on the modules; this package holds
// only encodings shared between them.
package nlp_pkg;

    // Kind of request held in the request register
    typedef enum logic {
        KIND_DEMAND   = 1'b0,
        KIND_PREFETCH = 1'b1
    } req_kind_e;

    // State of the prefetch slot
    typedef enum logic {
        PF_IDLE = 1'b0,
        PF_WAIT = 1'b1
    } pf_state_e;

endpackage

// File: rtl/nlp_addr_gen.sv
// Per-lane address generation.
// Forms each lane's effective address as base + offset, together with the
// next-word address (effective + WORD_BYTES). Purely combinational.
// Assumes: lane i occupies bits [i*AW +: AW] of the flat vectors; sums wrap at 2^AW.
module nlp_addr_gen #(
    parameter int LANES      = 4,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [LANES*AW-1:0] base_i,
    input  logic [AW-1:0]       offset_i,
    output logic [LANES*AW-1:0] eff_o,
    output logic [LANES*AW-1:0] next_o
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [AW-1:0] sum;
        // Lane adder: effective address and its next-word neighbour
        always_comb begin
            sum                 = base_i[g*AW +: AW] + offset_i;
            eff_o[g*AW +: AW]   = sum;
            next_o[g*AW +: AW]  = sum + STEP;
        end
    end
endmodule

// File: rtl/nlp_pf_ctrl.sv
// Prefetch slot controller.
// Captures the next-word addresses and lane mask of an accepted load with at
// least one enabled lane, and holds them until the request register can take them.
// Assumes: accept_i is only raised while the slot is idle (the top gates ready).
module nlp_pf_ctrl #(
    parameter int LANES = 4,
    parameter int AW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_i,
    input  logic                acc_read_i,
    input  logic [LANES-1:0]    acc_mask_i,
    input  logic [LANES*AW-1:0] acc_next_i,
    input  logic                load_en_i,
    output logic                pending_o,
    output logic [LANES*AW-1:0] pf_addr_o,
    output logic [LANES-1:0]    pf_mask_o
);
    import nlp_pkg::*;

    pf_state_e state_q;
    logic      trigger;

    // Decide whether an accepted demand spawns a prefetch
    always_comb trigger = accept_i && acc_read_i && (|acc_mask_i);

    // Slot state: fill on a trigger, drain when the register takes the prefetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PF_IDLE;
        end else if (state_q == PF_IDLE) begin
            if (trigger) state_q <= PF_WAIT;
        end else if (load_en_i) begin
            state_q <= PF_IDLE;
        end
    end

    // Slot payload: captured only on a trigger, so it stays put while waiting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_addr_o <= '0;
            pf_mask_o <= '0;
        end else if (trigger && state_q == PF_IDLE) begin
            pf_addr_o <= acc_next_i;
            pf_mask_o <= acc_mask_i;
        end
    end

    // Expose the slot occupancy
    always_comb pending_o = (state_q == PF_WAIT);
endmodule

// File: rtl/nlp_req_reg.sv
// Single-entry request register that feeds the cache.
// On every cycle with en_i high, the cache takes the current content and the
// register loads the incoming request (or becomes empty). With en_i low it holds.
// Assumes: en_i is the cache-not-busy indication.
module nlp_req_reg #(
    parameter int LANES = 4,
    parameter int AW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_i,
    input  logic                in_valid_i,
    input  logic [LANES*AW-1:0] in_addr_i,
    input  logic                in_read_i,
    input  logic [LANES-1:0]    in_mask_i,
    input  nlp_pkg::req_kind_e  in_kind_i,
    output logic                out_valid_o,
    output logic [LANES*AW-1:0] out_addr_o,
    output logic                out_read_o,
    output logic [LANES-1:0]    out_mask_o,
    output nlp_pkg::req_kind_e  out_kind_o
);
    import nlp_pkg::*;

    // Valid bit: advances only when the cache is ready
    always_ff @(posedge clk) begin
        if (!rst_n)    out_valid_o <= 1'b0;
        else if (en_i) out_valid_o <= in_valid_i;
    end

    // Payload: loaded only when a real request enters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr_o <= '0;
            out_read_o <= 1'b0;
            out_mask_o <= '0;
            out_kind_o <= KIND_DEMAND;
        end else if (en_i && in_valid_i) begin
            out_addr_o <= in_addr_i;
            out_read_o <= in_read_i;
            out_mask_o <= in_mask_i;
            out_kind_o <= in_kind_i;
        end
    end
endmodule

// File: rtl/nlp_inject.sv
// Next-line prefetch injector (top).
// Accepts demand requests on valid/ready, computes lane addresses, and places
// either the demand or a waiting next-word prefetch into a one-entry register
// toward the cache. The prefetch always takes precedence, and ready is withheld
// while it waits.
// Assumes: issue holds its request stable until the handshake.
module nlp_inject #(
    parameter int LANES      = 4,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dmd_valid,
    output logic                dmd_ready,
    input  logic [LANES*AW-1:0] dmd_base,
    input  logic [AW-1:0]       dmd_offset,
    input  logic                dmd_read,
    input  logic [LANES-1:0]    dmd_lane_en,
    input  logic                cache_ready,
    output logic                req_valid,
    output logic [LANES*AW-1:0] req_addr,
    output logic                req_read,
    output logic [LANES-1:0]    req_lane_en,
    output logic                req_is_pf
);
    import nlp_pkg::*;

    logic [LANES*AW-1:0] eff_addr, next_addr, pf_addr, sel_addr;
    logic [LANES-1:0]    pf_mask, sel_mask;
    logic                pf_pending, accept, sel_valid, sel_read;
    req_kind_e           sel_kind, out_kind;

    nlp_addr_gen #(.LANES(LANES), .AW(AW), .WORD_BYTES(WORD_BYTES)) u_addr (
        .base_i   (dmd_base),
        .offset_i (dmd_offset),
        .eff_o    (eff_addr),
        .next_o   (next_addr)
    );

    // Handshake: ready only when the cache is free and no prefetch waits
    always_comb begin
        dmd_ready = cache_ready && !pf_pending;
        accept    = dmd_valid && dmd_ready;
    end

    nlp_pf_ctrl #(.LANES(LANES), .AW(AW)) u_pf (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .acc_read_i (dmd_read),
        .acc_mask_i (dmd_lane_en),
        .acc_next_i (next_addr),
        .load_en_i  (cache_ready),
        .pending_o  (pf_pending),
        .pf_addr_o  (pf_addr),
        .pf_mask_o  (pf_mask)
    );

    // Demand/prefetch mux into the request register
    always_comb begin
        if (pf_pending) begin
            sel_valid = 1'b1;
            sel_addr  = pf_addr;
            sel_read  = 1'b1;
            sel_mask  = pf_mask;
            sel_kind  = KIND_PREFETCH;
        end else begin
            sel_valid = accept;
            sel_addr  = eff_addr;
            sel_read  = dmd_read;
            sel_mask  = dmd_lane_en;
            sel_kind  = KIND_DEMAND;
        end
    end

    nlp_req_reg #(.LANES(LANES), .AW(AW)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (cache_ready),
        .in_valid_i  (sel_valid),
        .in_addr_i   (sel_addr),
        .in_read_i   (sel_read),
        .in_mask_i   (sel_mask),
        .in_kind_i   (sel_kind),
        .out_valid_o (req_valid),
        .out_addr_o  (req_addr),
        .out_read_o  (req_read),
        .out_mask_o  (req_lane_en),
        .out_kind_o  (out_kind)
    );

    // Metadata flag toward the cache
    always_comb req_is_pf = (out_kind == KIND_PREFETCH);
endmodule

// File: rtl/nlp_inject_chk.sv
// Port-level checker for nlp_inject, bound into every instance.
// Assumes: synchronous active-low reset; checks start after reset is released.
module nlp_inject_chk #(
    parameter int LANES = 4,
    parameter int AW    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dmd_valid,
    input logic                dmd_ready,
    input logic                dmd_read,
    input logic [LANES-1:0]    dmd_lane_en,
    input logic                cache_ready,
    input logic                req_valid,
    input logic [LANES*AW-1:0] req_addr,
    input logic                req_read,
    input logic [LANES-1:0]    req_lane_en,
    input logic                req_is_pf
);
    logic hs;
    always_comb hs = dmd_valid && dmd_ready;

    // R3: an accepted demand shows up as a demand request next cycle
    p_demand_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> (req_valid && !req_is_pf));

    // R4: a prefetch on the output is always a read
    p_pf_is_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_pf) |-> req_read);

    // R5: writes do not block the next demand
    p_write_no_pf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && !dmd_read) |=> (dmd_ready == cache_ready));

    // R6: a triggering load blocks ready in the following cycle
    p_block_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs && dmd_read && (|dmd_lane_en)) |=> !dmd_ready);

    // R7: a busy cache freezes the register
    p_hold_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_ready |=> ($stable(req_valid) && $stable(req_addr) && $stable(req_read)
                          && $stable(req_lane_en) && $stable(req_is_pf)));

    // R8: nothing to send empties the register
    p_idle_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_ready && dmd_ready && !dmd_valid) |=> !req_valid);
endmodule

bind nlp_inject nlp_inject_chk #(.LANES(LANES), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dmd_valid   (dmd_valid),
    .dmd_ready   (dmd_ready),
    .dmd_read    (dmd_read),
    .dmd_lane_en (dmd_lane_en),
    .cache_ready (cache_ready),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_read    (req_read),
    .req_lane_en (req_lane_en),
    .req_is_pf   (req_is_pf)
);

// File: tb/nlp_inject_bench.sv
// Self-checking bench for nlp_inject: directed corners followed by seeded random traffic.
module nlp_inject_bench;
    localparam int LANES  = 4;
    localparam int AW     = 32;
    localparam int WB     = 4;
    localparam int FW     = LANES * AW;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dmd_valid, dmd_ready, dmd_read, cache_ready;
    logic [FW-1:0] dmd_base, req_addr;
    logic [AW-1:0] dmd_offset;
    logic [LANES-1:0] dmd_lane_en, req_lane_en;
    logic          req_valid, req_read, req_is_pf;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    logic          m_valid, m_read, m_pf, m_pend;
    logic [FW-1:0] m_addr, p_addr;
    logic [LANES-1:0] m_mask, p_mask;
    string         m_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    nlp_inject #(.LANES(LANES), .AW(AW), .WORD_BYTES(WB)) u_nlp_inject (
        .clk(clk), .rst_n(rst_n),
        .dmd_valid(dmd_valid), .dmd_ready(dmd_ready),
        .dmd_base(dmd_base), .dmd_offset(dmd_offset),
        .dmd_read(dmd_read), .dmd_lane_en(dmd_lane_en),
        .cache_ready(cache_ready),
        .req_valid(req_valid), .req_addr(req_addr), .req_read(req_read),
        .req_lane_en(req_lane_en), .req_is_pf(req_is_pf)
    );

    function automatic logic [FW-1:0] lane_add(input logic [FW-1:0] b, input logic [AW-1:0] o);
        logic [FW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*AW +: AW] = b[i*AW +: AW] + o;
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare request outputs with the model
    task automatic check_outputs();
        chk(m_tag, "req_valid", FW'(req_valid), FW'(m_valid));
        if (m_valid) begin
            chk(m_pf ? "R4" : "R1", "req_addr", req_addr, m_addr);
            chk(m_tag, "req_read", FW'(req_read), FW'(m_read));
            chk(m_tag, "req_lane_en", FW'(req_lane_en), FW'(m_mask));
            chk(m_tag, "req_is_pf", FW'(req_is_pf), FW'(m_pf));
        end
    endtask

    // One clock: check, drive, check ready, advance model on the edge
    task automatic cyc(input logic v, input logic rd, input logic [LANES-1:0] mk,
                       input logic [FW-1:0] b, input logic [AW-1:0] o, input logic cr);
        logic hs;
        check_outputs();
        dmd_valid = v; dmd_read = rd; dmd_lane_en = mk;
        dmd_base = b; dmd_offset = o; cache_ready = cr;
        #1;
        chk(m_pend ? "R6" : "R2", "dmd_ready", FW'(dmd_ready), FW'(cr && !m_pend));
        hs = v && cr && !m_pend;
        @(posedge clk);
        if (!cr) begin
            m_tag = "R7";
        end else if (m_pend) begin
            m_valid = 1'b1; m_addr = p_addr; m_read = 1'b1; m_mask = p_mask; m_pf = 1'b1;
            m_pend = 1'b0; m_tag = "R4";
        end else if (hs) begin
            m_valid = 1'b1; m_addr = lane_add(b, o); m_read = rd; m_mask = mk; m_pf = 1'b0;
            m_tag = "R3";
            if (rd && (|mk)) begin
                m_pend = 1'b1;
                p_addr = lane_add(b, o + AW'(WB));
                p_mask = mk;
            end
        end else begin
            m_valid = 1'b0; m_tag = "R8";
        end
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic          hv, hrd;
        logic [LANES-1:0] hmk;
        logic [FW-1:0] hb;
        logic [AW-1:0] ho;
        logic [31:0]   seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        rst_n = 1'b0; dmd_valid = 1'b0; dmd_read = 1'b0; dmd_lane_en = '0;
        dmd_base = '0; dmd_offset = '0; cache_ready = 1'b0;
        m_valid = 1'b0; m_read = 1'b0; m_pf = 1'b0; m_pend = 1'b0;
        m_addr = '0; p_addr = '0; m_mask = '0; p_mask = '0; m_tag = "R9";
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk("R9", "req_valid after reset", FW'(req_valid), '0);
        cache_ready = 1'b1; #1;
        chk("R9", "dmd_ready after reset", FW'(dmd_ready), FW'(1));
        rst_n = 1'b1;
        @(negedge clk);

        // R3/R4: load, prefetch follows the next cycle
        cyc(1, 1, 4'b1011, {32'h400, 32'h300, 32'h200, 32'h100}, 32'h10, 1);
        cyc(1, 1, 4'b1111, '0, 32'h0, 1);
        cyc(0, 0, 4'b0000, '0, 32'h0, 1);
        // R7: prefetch waits while the cache is busy, ready stays low
        cyc(1, 1, 4'b0110, {32'hA0, 32'hB0, 32'hC0, 32'hD0}, 32'h8, 1);
        cyc(1, 0, 4'b1111, '0, 32'h0, 0);
        cyc(1, 0, 4'b1111, '0, 32'h0, 0);
        cyc(1, 0, 4'b1111, '0, 32'h0, 0);
        cyc(1, 0, 4'b1111, {32'h1, 32'h2, 32'h3, 32'h4}, 32'h0, 1);
        cyc(1, 0, 4'b1111, {32'h1, 32'h2, 32'h3, 32'h4}, 32'h0, 1);
        // R5: write spawns no prefetch, ready stays up
        chk("R5", "dmd_ready after write", FW'(dmd_ready), FW'(1));
        cyc(1, 1, 4'b0000, {32'h50, 32'h60, 32'h70, 32'h80}, 32'h4, 1);
        chk("R5", "dmd_ready after empty-mask read", FW'(dmd_ready), FW'(1));
        // R1/R4: address wrap at the top of the space
        cyc(1, 1, 4'b1000, {32'hFFFF_FFF0, 32'h0, 32'hFFFF_FFFC, 32'h8}, 32'hC, 1);
        cyc(0, 0, 4'b0000, '0, 32'h0, 1);
        cyc(0, 0, 4'b0000, '0, 32'h0, 1);

        // Seeded random traffic; issue holds its request until accepted
        hv = 1'b0; hrd = 1'b0; hmk = '0; hb = '0; ho = '0;
        for (int k = 0; k < 800; k++) begin
            logic cr;
            if (!(hv && !dmd_ready_hold())) begin
                hv  = ($urandom % 10) < 7;
                hrd = ($urandom % 10) < 6;
                hmk = ($urandom % 5 == 0) ? '0 : LANES'($urandom);
                for (int i = 0; i < LANES; i++) hb[i*AW +: AW] = $urandom;
                ho  = AW'($urandom % 4096);
            end
            cr = ($urandom % 4) != 0;
            cyc(hv, hrd, hmk, hb, ho, cr);
            last_hs = hv && cr && !pend_before;
        end
        check_outputs();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Handshake record of the previous random cycle, used to keep a request held
    logic last_hs = 1'b0;
    logic pend_before = 1'b0;
    always @(negedge clk) pend_before <= m_pend;
    function automatic logic dmd_ready_hold();
        return last_hs;
    endfunction
endmodule